// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is a single output-compare channel built around its own 16-bit up-counter. The counter steps by one on each incoming tick while the timer is enabled, and it wraps from all ones back to zero. The channel holds a compare value. A compare event happens when the counter reaches that value, or when software writes a force strobe. Each event does two things: it applies a programmed action to the channel's output pin, and it sets a sticky event flag. The flag can raise an interrupt request.

Software reaches the channel through a small register port with four word addresses. The writes take effect on the clock edge. Reads are combinational from the address. The tick comes from a prescaler outside the block. Software arms a delay by reading the counter, adding an offset and writing the sum as the compare value. It then clears the flag and waits for the flag or the interrupt.

Top module: `oc_channel`

## Requirements
- R1: After reset the counter, the compare value, the control word, the flag and the pin level are all zero. The outputs `oc_irq` and `oc_pin_oe` are low.
- R2: The counter (address 0, read-only) adds one on each clock where `cnt_tick` is 1 and the enable bit (control bit 0) is 1. It holds its value otherwise, and it wraps from 0xFFFF to 0x0000.
- R3: While enabled, a counter value equal to the compare value (address 1) causes a compare event. One cycle later the flag (status bit 0) reads 1 and the pin action has been applied.
- R4: A counter value that matches yields only one event. If the counter stalls on that value, no further event occurs. Matching is re-armed when the counter advances, when the compare value is written, or when the timer is disabled.
- R5: Writing 1 to status bit 1 (the force strobe) causes a compare event whatever the counter holds, even with the timer disabled. This bit always reads 0.
- R6: The action field is control bits 2:1. On an event, 00 leaves the pin level unchanged, 01 inverts it, 10 makes it 0 and 11 makes it 1. Status bit 2 reads the pin level back.
- R7: Writing 1 to status bit 0 clears the flag. Writing 0 leaves it unchanged. No write can set it; only an event does.
- R8: If an event and a write-1 clear of the flag fall in the same cycle, the flag ends up set.
- R9: `oc_irq` is 1 exactly when the flag is 1 and the mask bit (control bit 3) is 1.
- R10: With the enable bit at 0, an equal counter and compare value produce no event. Neither the flag nor the pin level changes.
- R11: When the compare-drive bit (control bit 4) is 1, `oc_pin_oe` is 1 and `oc_pin` carries the pin level, whatever `port_dir` is. When it is 0, `oc_pin_oe` equals `port_dir` and `oc_pin` equals `port_dout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_tick | input | 1 | Counter step request from the prescaler |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address: 0 counter, 1 compare, 2 control, 3 status |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| port_dir | input | 1 | General-purpose direction for the pin when compare drive is off |
| port_dout | input | 1 | General-purpose data for the pin when compare drive is off |
| oc_pin | output | 1 | Pin value |
| oc_pin_oe | output | 1 | Pin output enable |
| oc_irq | output | 1 | Interrupt request |

## Verification
A wrong match re-arm latch shows up within a cycle as a flag that comes back after a clear while the counter is stalled. With a toggle action, the same fault also shows as a pin that flips again. A counter that steps wrongly or wraps wrongly can be seen directly on the counter readback. It also moves the cycle in which a programmed compare value sets the flag. A fault in the flag priority or the action decode shows on `oc_irq`, on the status readback and on `oc_pin` in the cycle right after the offending write.

// File: rtl/oc_pkg.sv
package oc_pkg;

  // Pin action applied on each compare event
  typedef enum logic [1:0] {
    ACT_HOLD   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_LOW    = 2'b10,
    ACT_HIGH   = 2'b11
  } pin_act_e;

  // Control word, bit 0 at the bottom: en, act[2:1], mask, oc_sel
  typedef struct packed {
    logic     oc_sel;
    logic     mask;
    pin_act_e act;
    logic     en;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);

  localparam logic [1:0] A_COUNT = 2'd0;
  localparam logic [1:0] A_CMP   = 2'd1;
  localparam logic [1:0] A_CTRL  = 2'd2;
  localparam logic [1:0] A_STAT  = 2'd3;

  localparam int unsigned STAT_FLAG  = 0;
  localparam int unsigned STAT_FORCE = 1;
  localparam int unsigned STAT_LEVEL = 2;
  localparam int unsigned STAT_W     = 3;

  function automatic logic apply_action(input pin_act_e a, input logic cur);
    logic nxt;
    case (a)
      ACT_TOGGLE: nxt = ~cur;
      ACT_LOW:    nxt = 1'b0;
      ACT_HIGH:   nxt = 1'b1;
      default:    nxt = cur;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/oc_counter.sv
module oc_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  output logic             advance,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] v);
    return v + ONE;
  endfunction

  assign advance = en & tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (advance) cnt <= bump(cnt);
  end

  a_r2_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> cnt == $past(cnt) + ONE);
  a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(cnt));

endmodule

// File: rtl/oc_match.sv
module oc_match #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             advance,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp,
  output logic             hit
);

  logic done_q;
  logic rearm;

  assign rearm = advance | cmp_wr | ~en;
  assign hit   = en & (cnt == cmp) & ~done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     done_q <= 1'b0;
    else if (rearm) done_q <= 1'b0;
    else if (hit)   done_q <= 1'b1;
  end

  a_r4_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !advance && !cmp_wr) |=> !hit);
  a_r10_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> en);

endmodule

// File: rtl/oc_pin_action.sv
module oc_pin_action
  import oc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     event_in,
  input  pin_act_e act,
  output logic     level
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        level <= 1'b0;
    else if (event_in) level <= apply_action(act, level);
  end

  a_r6_toggle_flips: assert property (@(posedge clk) disable iff (!rst_n)
    (event_in && act == ACT_TOGGLE) |=> level != $past(level));
  a_r6_low_high: assert property (@(posedge clk) disable iff (!rst_n)
    (event_in && act[1]) |=> level == $past(act[0]));
  a_r6_no_event_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !event_in |=> $stable(level));

endmodule

// File: rtl/oc_event_flag.sv
module oc_event_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic event_in,
  input  logic clr,
  output logic flag
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag <= 1'b0;
    else if (event_in) flag <= 1'b1;
    else if (clr)      flag <= 1'b0;
  end

  a_r8_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    event_in |=> flag);
  a_r7_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !event_in) |=> !flag);
  a_r7_no_soft_set: assert property (@(posedge clk) disable iff (!rst_n)
    !event_in |=> !$rose(flag));

endmodule

// File: rtl/oc_channel.sv
module oc_channel
  import oc_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_tick,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  input  logic             port_dir,
  input  logic             port_dout,
  output logic             oc_pin,
  output logic             oc_pin_oe,
  output logic             oc_irq
);

  localparam int unsigned CTRL_PAD = CNT_W - CTRL_W;
  localparam int unsigned STAT_PAD = CNT_W - STAT_W;

  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] cmp_q;
  logic [CNT_W-1:0] cnt;
  logic             wr_cmp, wr_ctrl, wr_stat;
  logic             force_ev, clr_req;
  logic             advance, match_hit, cmp_event;
  logic             flag, level;

  assign wr_cmp   = reg_wr && (reg_addr == A_CMP);
  assign wr_ctrl  = reg_wr && (reg_addr == A_CTRL);
  assign wr_stat  = reg_wr && (reg_addr == A_STAT);
  assign force_ev = wr_stat && reg_wdata[STAT_FORCE];
  assign clr_req  = wr_stat && reg_wdata[STAT_FLAG];
  assign cmp_event = match_hit | force_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q  <= '0;
      ctrl_q <= '0;
    end else begin
      if (wr_cmp)  cmp_q  <= reg_wdata;
      if (wr_ctrl) ctrl_q <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
    end
  end

  oc_counter #(.CNT_W(CNT_W)) u_counter (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (ctrl_q.en),
    .tick    (cnt_tick),
    .advance (advance),
    .cnt     (cnt)
  );

  oc_match #(.CNT_W(CNT_W)) u_match (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (ctrl_q.en),
    .advance (advance),
    .cmp_wr  (wr_cmp),
    .cnt     (cnt),
    .cmp     (cmp_q),
    .hit     (match_hit)
  );

  oc_pin_action u_action (
    .clk      (clk),
    .rst_n    (rst_n),
    .event_in (cmp_event),
    .act      (ctrl_q.act),
    .level    (level)
  );

  oc_event_flag u_flag (
    .clk      (clk),
    .rst_n    (rst_n),
    .event_in (cmp_event),
    .clr      (clr_req),
    .flag     (flag)
  );

  always_comb begin
    case (reg_addr)
      A_COUNT: reg_rdata = cnt;
      A_CMP:   reg_rdata = cmp_q;
      A_CTRL:  reg_rdata = {{CTRL_PAD{1'b0}}, ctrl_q};
      default: reg_rdata = {{STAT_PAD{1'b0}}, level, 1'b0, flag};
    endcase
  end

  assign oc_irq    = flag & ctrl_q.mask;
  assign oc_pin_oe = ctrl_q.oc_sel | port_dir;
  assign oc_pin    = ctrl_q.oc_sel ? level : port_dout;

  a_r10_disabled_still: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.en && !force_ev) |=> ($stable(level) && !$rose(flag) && $stable(cnt)));
  a_r5_force_sets: assert property (@(posedge clk) disable iff (!rst_n)
    force_ev |=> oc_irq == ctrl_q.mask);

endmodule

// File: tb/oc_channel_test.sv
`timescale 1ns/1ps
module oc_channel_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_tick = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        port_dir = 1'b0;
  logic        port_dout = 1'b0;
  logic        oc_pin, oc_pin_oe, oc_irq;

  int n_checks = 0;
  int n_err = 0;
  bit done = 0;

  // reference state
  logic [15:0] m_cnt = '0, m_cmp = '0;
  logic [4:0]  m_ctrl = '0;
  logic        m_flag = 0, m_level = 0, m_armed_off = 0;

  always #2 clk = ~clk;

  oc_channel uut (
    .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .port_dir(port_dir), .port_dout(port_dout), .oc_pin(oc_pin),
    .oc_pin_oe(oc_pin_oe), .oc_irq(oc_irq)
  );

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  // R6 action code: 00 hold, 01 invert, 10 low, 11 high
  function automatic logic act_of(input logic [1:0] code, input logic cur);
    if (code == 2'b01) return !cur;
    if (code == 2'b10) return 1'b0;
    if (code == 2'b11) return 1'b1;
    return cur;
  endfunction

  function automatic logic [15:0] exp_read(input logic [1:0] a);
    case (a)
      2'd0: return m_cnt;
      2'd1: return m_cmp;
      2'd2: return {11'd0, m_ctrl};
      default: return {13'd0, m_level, 1'b0, m_flag};
    endcase
  endfunction

  task automatic model(input logic t, input logic w, input logic [1:0] a, input logic [15:0] d);
    logic en, adv, cw, frc, clr, hit, ev;
    en  = m_ctrl[0];
    adv = t & en;
    cw  = w && a == 2'd1;
    frc = w && a == 2'd3 && d[1];
    clr = w && a == 2'd3 && d[0];
    hit = en && (m_cnt == m_cmp) && !m_armed_off;
    ev  = hit | frc;
    if (ev) m_flag = 1'b1; else if (clr) m_flag = 1'b0;
    if (ev) m_level = act_of(m_ctrl[2:1], m_level);
    if (adv || cw || !en) m_armed_off = 1'b0; else if (hit) m_armed_off = 1'b1;
    if (adv) m_cnt = m_cnt + 16'd1;
    if (cw) m_cmp = d;
    if (w && a == 2'd2) m_ctrl = d[4:0];
  endtask

  task automatic check_outs();
    chk("R9 irq", {15'd0, oc_irq}, {15'd0, m_flag & m_ctrl[3]});
    chk("R11 oe", {15'd0, oc_pin_oe}, {15'd0, m_ctrl[4] | port_dir});
    chk("R11 pin", {15'd0, oc_pin}, {15'd0, m_ctrl[4] ? m_level : port_dout});
  endtask

  task automatic step(input logic t, input logic w, input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    cnt_tick = t; reg_wr = w; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    model(t, w, a, d);
    #1;
    reg_wr = 1'b0;
    cnt_tick = 1'b0;
    check_outs();
  endtask

  task automatic rd(input string req, input logic [1:0] a);
    reg_addr = a;
    #0.2;
    chk(req, reg_rdata, exp_read(a));
  endtask

  initial begin
    #790000;
    if (!done) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog actual=%h expected=%h", 16'd0, 16'd1);
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h0C5E_ED01));
    #9 rst_n = 1'b1;
    #1;
    // R1 reset state
    rd("R1 count", 2'd0); rd("R1 compare", 2'd1);
    rd("R1 control", 2'd2); rd("R1 status", 2'd3);
    chk("R1 irq", {15'd0, oc_irq}, 16'd0);
    chk("R1 oe", {15'd0, oc_pin_oe}, 16'd0);

    // R10 / R2: disabled, counter equals compare, ticks arrive
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 2'd0, 16'd0);
    rd("R10 no flag while disabled", 2'd3);
    rd("R2 no count while disabled", 2'd0);

    // R3: enable, toggle, mask, compare drive; counter 0 matches compare 0
    step(1'b0, 1'b1, 2'd2, 16'h001B);
    step(1'b0, 1'b0, 2'd0, 16'd0);
    chk("R3 flag after match", {15'd0, m_flag}, 16'd1);
    rd("R3 status after match", 2'd3);
    chk("R6 toggle to one", {15'd0, oc_pin}, 16'd1);
    chk("R9 irq raised", {15'd0, oc_irq}, 16'd1);

    // R4: stalled counter, clear flag, no re-fire
    step(1'b0, 1'b1, 2'd3, 16'h0001);
    for (int i = 0; i < 5; i++) step(1'b0, 1'b0, 2'd0, 16'd0);
    rd("R4 no repeat on stall", 2'd3);
    chk("R4 pin kept", {15'd0, oc_pin}, 16'd1);

    // R5 force with no match (counter 0, compare 9)
    step(1'b0, 1'b1, 2'd1, 16'd9);
    step(1'b0, 1'b1, 2'd3, 16'h0002);
    rd("R5 force sets flag", 2'd3);
    rd("R5 force bit reads zero", 2'd3);
    // R7 write zero does nothing, write one clears
    step(1'b0, 1'b1, 2'd3, 16'h0000);
    chk("R7 zero write ignored", {15'd0, oc_irq}, 16'd1);
    step(1'b0, 1'b1, 2'd3, 16'h0001);
    chk("R7 cleared", {15'd0, oc_irq}, 16'd0);
    // R8 force and clear together
    step(1'b0, 1'b1, 2'd3, 16'h0003);
    rd("R8 event beats clear", 2'd3);
    chk("R8 flag set", {15'd0, oc_irq}, 16'd1);

    // R6 action codes: low, high, hold (mask off, compare drive on)
    step(1'b0, 1'b1, 2'd2, 16'h0015);
    step(1'b0, 1'b1, 2'd3, 16'h0002);
    chk("R6 drive low", {15'd0, oc_pin}, 16'd0);
    step(1'b0, 1'b1, 2'd2, 16'h0017);
    step(1'b0, 1'b1, 2'd3, 16'h0002);
    chk("R6 drive high", {15'd0, oc_pin}, 16'd1);
    step(1'b0, 1'b1, 2'd2, 16'h0011);
    step(1'b0, 1'b1, 2'd3, 16'h0002);
    chk("R6 hold", {15'd0, oc_pin}, 16'd1);
    chk("R9 mask off", {15'd0, oc_irq}, 16'd0);

    // R11 general-purpose path
    step(1'b0, 1'b1, 2'd2, 16'h0001);
    port_dir = 1'b0; port_dout = 1'b1; #0.2;
    chk("R11 oe follows dir", {15'd0, oc_pin_oe}, 16'd0);
    chk("R11 pin follows data", {15'd0, oc_pin}, 16'd1);
    port_dir = 1'b1; port_dout = 1'b0; #0.2;
    chk("R11 oe follows dir high", {15'd0, oc_pin_oe}, 16'd1);
    step(1'b0, 1'b1, 2'd2, 16'h0013);
    port_dir = 1'b0; #0.2;
    chk("R11 drive overrides dir", {15'd0, oc_pin_oe}, 16'd1);

    // R2 wrap and R3 match at the top value
    step(1'b0, 1'b1, 2'd3, 16'h0001);
    step(1'b0, 1'b1, 2'd1, 16'hFFFF);
    while (m_cnt != 16'hFFFF) step(1'b1, 1'b0, 2'd0, 16'd0);
    rd("R2 reaches top", 2'd0);
    step(1'b1, 1'b0, 2'd0, 16'd0);
    rd("R2 wrap to zero", 2'd0);
    rd("R3 match at top", 2'd3);

    // constrained random phase
    for (int i = 0; i < 3000; i++) begin
      int unsigned op;
      logic t;
      op = $urandom % 16;
      t = ($urandom % 4) != 0;
      port_dir = $urandom % 2;
      port_dout = $urandom % 2;
      if (op < 2)
        step(t, 1'b1, 2'd1, m_cnt + 16'($urandom % 6));
      else if (op == 2)
        step(t, 1'b1, 2'd2, {11'd0, 4'($urandom), ($urandom % 8) != 0});
      else if (op == 3)
        step(t, 1'b1, 2'd3, {14'd0, 2'($urandom)});
      else
        step(t, 1'b0, 2'd0, 16'd0);
      rd("R3/R4/R6/R7/R8 random readback", 2'($urandom));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

endmodule